// File: doc/BRIEF.md
# Status-Polled NOR Flash Erase and Program Sequencer

This block runs the write side of a NOR flash whose commands take two bus cycles and whose progress is reported through a status byte. On a start pulse it either erases the block that holds a given byte offset, or programs a run of consecutive bytes starting at that offset. The bytes to program arrive on a valid/ready stream. After each command the engine reads status at the target offset until the device reports ready. It then inspects the error bits and enforces a cycle-count limit. Address decoding, geometry discovery and bus timing belong to the surrounding logic.

The flash side is a plain synchronous port. A cycle with `fl_wr` high writes `fl_wdata` at `fl_addr`. A cycle with `fl_rd` high requests a read, and `fl_rdata` must hold the byte read in the following cycle. The stream follows the usual rules. A byte moves on a cycle where `s_valid` and `s_ready` are both high. `s_ready` is raised only in the one step where a program command waits for its data byte. While `s_valid` stays low the engine holds in that step and issues no bus write, so the producer applies back-pressure simply by withholding data. The producer must hold `s_data` stable while `s_valid` is high.

The status byte uses bit 7 as ready (1 = the device has finished). Bits 6:0 are error flags. The two timeout limits are read live and must stay stable while `busy` is high.

Top module: `nor_stat_engine`

## Requirements
- R1: After reset `busy`, `done`, `err`, `err_tmo`, `fl_wr`, `fl_rd` and `s_ready` are all 0.
- R2: Every accepted operation first writes 0xFF at address 0, and that write occurs in the first cycle `busy` is high.
- R3: An erase (`op_erase`=1) writes 0x20 and then 0xD0, both at `base_off`, before polling.
- R4: A program (`op_erase`=0) handles `blk_len` bytes, one at a time, at offsets `base_off`, `base_off`+1, and so on. For each byte it writes 0xFF at 0, then 0x40 at the offset, then the stream byte at the offset. A stream byte is taken only in that last step, and that step waits with no bus write while `s_valid` is low.
- R5: After a command, the engine reads status at the target offset, and it repeats the read while bit 7 of the returned byte is 0. A read is never issued in the same cycle as a write, and a read is never issued in the cycle right after another read.
- R6: If a status byte has bit 7 set and any of bits 6:0 set, the operation ends at once with `err`=1 and `err_tmo`=0. No further bus write follows.
- R7: If a status byte has bit 7 clear and more than the limit of cycles have passed since the command's last write, the operation ends with `err`=1 and `err_tmo`=1. Erase uses `erase_tmo` as the limit and program uses `write_tmo`. If bit 7 is set, it is honoured even when the limit has already passed.
- R8: The timeout count restarts for each programmed byte, so only the time spent on a single byte is compared against `write_tmo`.
- R9: A successful operation ends with a write of 0xFF at address 0, and then `done` is raised with `err`=0.
- R10: On failure, `err_status` holds the last status byte and `err_off` holds the offset being processed. Both values, together with `err` and `err_tmo`, hold until the next accepted start, which clears them.
- R11: A start pulse while `busy` is high is ignored.
- R12: A program with `blk_len`=0 takes no stream byte. It writes only 0xFF at 0 twice and then finishes without error.
- R13: `done` is a one-cycle pulse, and it comes in the first cycle after `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op_erase | input | 1 | 1 = block erase, 0 = program bytes |
| base_off | input | AW | Byte offset of the block or of the first byte |
| blk_len | input | AW+1 | Number of bytes to program |
| erase_tmo | input | TW | Cycle limit for an erase |
| write_tmo | input | TW | Cycle limit for each programmed byte |
| s_valid | input | 1 | Stream byte available |
| s_ready | output | 1 | Engine takes the stream byte |
| s_data | input | 8 | Stream byte |
| fl_wr | output | 1 | Flash write strobe |
| fl_rd | output | 1 | Flash read strobe |
| fl_addr | output | AW | Flash byte address |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data, valid the cycle after `fl_rd` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Last operation failed |
| err_tmo | output | 1 | Failure was a timeout |
| err_status | output | 8 | Status byte seen at failure |
| err_off | output | AW | Offset being processed at failure |

## Verification
The bench predicts every bus write in order and stalls the stream between bytes. A design that wrote the data byte without a handshake, or that skipped the per-byte reset, would therefore produce a write the scoreboard does not expect. Failure cases include an error bit on the third byte of a run, which must stop the run without the final reset and report that offset. They also include a ready status arriving with a zero limit, which must still count as success. Each byte of one run is made to take nearly the full write limit, so a count that did not restart per byte would report a false timeout. Erase and program are each run against a tight limit belonging to the other mode, so swapping the two limits shows up. A second start issued mid-erase and a zero-length program each catch an engine that restarts or that pulls a stray byte from the stream.

// File: rtl/nse_pkg.sv
package nse_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RST, ST_CMD1, ST_CMD2, ST_RD, ST_CHK, ST_FIN
  } nse_state_e;

  localparam logic [7:0] CMD_READ_MODE   = 8'hFF;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] CMD_PROG_BYTE   = 8'h40;
  localparam int         RDY_BIT         = 7;
  localparam logic [7:0] FAIL_MASK       = 8'h7F;
endpackage

// File: rtl/nse_timer.sv
module nse_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  // saturating elapsed-cycle count since the last command write
  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (clr)                 cnt_q <= '0;
    else if (run && cnt_q != '1)  cnt_q <= cnt_q + 1'b1;
  end

  assign expired = cnt_q > limit;
endmodule

// File: rtl/nse_fail_latch.sv
module nse_fail_latch #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cap_hw,
  input  logic          cap_tmo,
  input  logic [7:0]    stat_in,
  input  logic [AW-1:0] off_in,
  output logic          err,
  output logic          err_tmo,
  output logic [7:0]    err_status,
  output logic [AW-1:0] err_off
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      err        <= 1'b0;
      err_tmo    <= 1'b0;
      err_status <= '0;
      err_off    <= '0;
    end else if (cap_hw || cap_tmo) begin
      err        <= 1'b1;
      err_tmo    <= cap_tmo;
      err_status <= stat_in;
      err_off    <= off_in;
    end
  end
endmodule

// File: rtl/nse_fsm.sv
module nse_fsm
  import nse_pkg::*;
#(
  parameter int AW = 12,
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_erase,
  input  logic [AW-1:0] base_off,
  input  logic [LW-1:0] blk_len,
  input  logic          s_valid,
  input  logic [7:0]    s_data,
  input  logic [7:0]    fl_rdata,
  input  logic          tmo_hit,
  output logic          s_ready,
  output logic          fl_wr,
  output logic          fl_rd,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_wdata,
  output logic          busy,
  output logic          launch,
  output logic          is_erase,
  output logic          tmr_clr,
  output logic          tmr_run,
  output logic          fin_ok,
  output logic          fin_hw,
  output logic          fin_tmo,
  output logic [AW-1:0] cur_off
);
  nse_state_e    state_q;
  logic          erase_q;
  logic [AW-1:0] off_q;
  logic [LW-1:0] left_q;
  logic          adv, rdy, bad;

  assign adv      = erase_q || s_valid;
  assign rdy      = fl_rdata[RDY_BIT];
  assign bad      = |(fl_rdata & FAIL_MASK);
  assign busy     = state_q != ST_IDLE;
  assign launch   = (state_q == ST_IDLE) && start;
  assign is_erase = erase_q;
  assign cur_off  = off_q;
  assign tmr_clr  = (state_q == ST_CMD2) && adv;
  assign tmr_run  = (state_q == ST_RD) || (state_q == ST_CHK);
  assign fin_ok   = state_q == ST_FIN;
  assign fin_hw   = (state_q == ST_CHK) && rdy && bad;
  assign fin_tmo  = (state_q == ST_CHK) && !rdy && tmo_hit;

  always_comb begin
    fl_wr    = 1'b0;
    fl_rd    = 1'b0;
    fl_addr  = off_q;
    fl_wdata = CMD_READ_MODE;
    s_ready  = 1'b0;
    unique case (state_q)
      ST_RST, ST_FIN: begin
        fl_wr   = 1'b1;
        fl_addr = '0;
      end
      ST_CMD1: begin
        fl_wr    = 1'b1;
        fl_wdata = erase_q ? CMD_ERASE_SETUP : CMD_PROG_BYTE;
      end
      ST_CMD2: begin
        s_ready  = !erase_q;
        fl_wr    = adv;
        fl_wdata = erase_q ? CMD_ERASE_GO : s_data;
      end
      ST_RD:   fl_rd = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      erase_q <= 1'b0;
      off_q   <= '0;
      left_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          erase_q <= op_erase;
          off_q   <= base_off;
          left_q  <= blk_len;
          state_q <= ST_RST;
        end
        ST_RST:  state_q <= (!erase_q && left_q == '0) ? ST_FIN : ST_CMD1;
        ST_CMD1: state_q <= ST_CMD2;
        ST_CMD2: if (adv) begin
          if (!erase_q) left_q <= left_q - 1'b1;
          state_q <= ST_RD;
        end
        ST_RD:   state_q <= ST_CHK;
        ST_CHK: begin
          if (rdy) begin
            if (bad)                        state_q <= ST_IDLE;
            else if (erase_q || left_q == '0) state_q <= ST_FIN;
            else begin
              off_q   <= off_q + 1'b1;
              state_q <= ST_RST;
            end
          end else if (tmo_hit) state_q <= ST_IDLE;
          else                  state_q <= ST_RD;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nor_stat_engine.sv
module nor_stat_engine #(
  parameter int AW = 12,
  parameter int TW = 16,
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_erase,
  input  logic [AW-1:0] base_off,
  input  logic [LW-1:0] blk_len,
  input  logic [TW-1:0] erase_tmo,
  input  logic [TW-1:0] write_tmo,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [7:0]    s_data,
  output logic          fl_wr,
  output logic          fl_rd,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_wdata,
  input  logic [7:0]    fl_rdata,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          err_tmo,
  output logic [7:0]    err_status,
  output logic [AW-1:0] err_off
);
  logic          launch, is_erase, tmr_clr, tmr_run, tmo_hit;
  logic          fin_ok, fin_hw, fin_tmo;
  logic [AW-1:0] cur_off;
  logic [TW-1:0] limit;

  assign limit = is_erase ? erase_tmo : write_tmo;

  nse_fsm #(.AW(AW)) fsm_i (
    .clk, .rst_n, .start, .op_erase, .base_off, .blk_len,
    .s_valid, .s_data, .fl_rdata, .tmo_hit,
    .s_ready, .fl_wr, .fl_rd, .fl_addr, .fl_wdata,
    .busy, .launch, .is_erase, .tmr_clr, .tmr_run,
    .fin_ok, .fin_hw, .fin_tmo, .cur_off
  );

  nse_timer #(.TW(TW)) tmr_i (
    .clk, .rst_n, .clr(tmr_clr), .run(tmr_run), .limit, .expired(tmo_hit)
  );

  nse_fail_latch #(.AW(AW)) fail_i (
    .clk, .rst_n, .clr(launch), .cap_hw(fin_hw), .cap_tmo(fin_tmo),
    .stat_in(fl_rdata), .off_in(cur_off),
    .err, .err_tmo, .err_status, .err_off
  );

  always_ff @(posedge clk) begin
    if (!rst_n) done <= 1'b0;
    else        done <= fin_ok || fin_hw || fin_tmo;
  end
endmodule

// File: rtl/nse_chk.sv
module nse_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic [7:0]    err_status,
  input logic          s_valid,
  input logic          s_ready,
  input logic [7:0]    s_data,
  input logic          fl_wr,
  input logic          fl_rd,
  input logic [AW-1:0] fl_addr,
  input logic [7:0]    fl_wdata
);
  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2
  open_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (fl_wr && fl_addr == '0 && fl_wdata == 8'hFF));
  // R4
  byte_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |-> (fl_wr && fl_wdata == s_data));
  // R5
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_wr && fl_rd));
  // R5
  rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_rd |=> (!fl_rd && !fl_wr));
  // R11
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R6
  fail_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!err_status[7] || err_status[6:0] != 7'd0));
  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(err_status) && $stable(err)));
endmodule

bind nor_stat_engine nse_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err(err), .err_status(err_status), .s_valid(s_valid), .s_ready(s_ready),
  .s_data(s_data), .fl_wr(fl_wr), .fl_rd(fl_rd), .fl_addr(fl_addr),
  .fl_wdata(fl_wdata)
);

// File: tb/nor_stat_engine_tb_top.sv
`timescale 1ns/1ps
module nor_stat_engine_tb_top;
  localparam int AW = 12;
  localparam int TW = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, op_erase = 1'b0;
  logic [AW-1:0] base_off = '0;
  logic [AW:0]   blk_len = '0;
  logic [TW-1:0] erase_tmo = '0, write_tmo = '0;
  logic s_valid = 1'b0, s_ready;
  logic [7:0] s_data = '0;
  logic fl_wr, fl_rd;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_wdata, fl_rdata = '0;
  logic busy, done, err, err_tmo;
  logic [7:0] err_status;
  logic [AW-1:0] err_off;

  always #2.5 clk = ~clk;

  nor_stat_engine #(.AW(AW), .TW(TW)) dut_i (.*);

  int n_vec = 0, n_bad = 0;
  logic [AW+7:0] exp_q[$];
  logic [7:0] strm_q[$];
  bit stall_en = 0;
  int cyc = 0;
  int busy_polls = 0, polls_left = 0, rdy_idx = 0;
  logic [7:0] rdy_seq[8];
  logic [AW-1:0] last_cmd_addr = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push_w(input logic [AW-1:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
  endtask

  // write scoreboard monitor + read address check
  always @(posedge clk) begin
    cyc++;
    if (rst_n && fl_wr) begin
      if (exp_q.size() == 0)
        chk(0, "R6/R9 unexpected write", int'({fl_addr, fl_wdata}), 0);
      else begin
        logic [AW+7:0] e;
        e = exp_q.pop_front();
        chk({fl_addr, fl_wdata} == e, "R2/R3/R4 write", int'({fl_addr, fl_wdata}), int'(e));
      end
    end
    if (rst_n && fl_rd)
      chk(fl_addr == last_cmd_addr, "R5 poll addr", int'(fl_addr), int'(last_cmd_addr));
  end

  // flash status model
  always @(posedge clk) begin
    if (fl_wr) begin
      polls_left = busy_polls;
      if (fl_addr != '0) last_cmd_addr = fl_addr;
    end
    if (fl_rd) begin
      if (polls_left > 0) begin
        fl_rdata <= 8'h00;
        polls_left--;
      end else begin
        fl_rdata <= rdy_seq[rdy_idx];
        if (rdy_idx < 7) rdy_idx++;
      end
    end
  end

  // stream producer
  always @(posedge clk)
    if (s_valid && s_ready) void'(strm_q.pop_front());
  always @(negedge clk) begin
    s_valid <= (strm_q.size() > 0) && !(stall_en && (cyc % 3 != 0));
    s_data  <= (strm_q.size() > 0) ? strm_q[0] : 8'h00;
  end

  task automatic set_status(input int bp);
    busy_polls = bp;
    rdy_idx = 0;
    foreach (rdy_seq[i]) rdy_seq[i] = 8'h80;
  endtask

  task automatic fire(input bit er, input logic [AW-1:0] off, input int len);
    @(negedge clk);
    op_erase = er; base_off = off; blk_len = len[AW:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(done, req, 0, 1);
  endtask

  task automatic end_checks(input string req, input bit e, input bit t,
                            input logic [7:0] st, input logic [AW-1:0] off);
    chk(err == e, {req, " err"}, err, e);
    chk(err_tmo == t, {req, " err_tmo"}, err_tmo, t);
    if (e) begin
      chk(err_status == st, {req, " err_status"}, err_status, st);
      chk(err_off == off, {req, " err_off"}, err_off, off);
    end
    chk(exp_q.size() == 0, {req, " writes left"}, exp_q.size(), 0);
    @(negedge clk);
    chk(!done, "R13 done pulse", done, 0);
  endtask

  task automatic exp_prog(input logic [AW-1:0] off, input logic [7:0] d);
    push_w('0, 8'hFF); push_w(off, 8'h40); push_w(off, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog actual=0x0 expected=0x1");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({busy, done, err, err_tmo, fl_wr, fl_rd, s_ready} == 7'b0, "R1 reset", 1, 0);

    // R3 R9 erase success
    set_status(3); erase_tmo = 16'd1000; write_tmo = 16'd1000;
    push_w('0, 8'hFF); push_w(12'h120, 8'h20); push_w(12'h120, 8'hD0); push_w('0, 8'hFF);
    fire(1, 12'h120, 0);
    wait_done("R9 erase done");
    end_checks("R3 erase", 0, 0, 0, 0);

    // R4 program with stream stalls
    set_status(2); stall_en = 1;
    strm_q = '{8'h11, 8'h22, 8'h33, 8'h44};
    exp_prog(12'h040, 8'h11); exp_prog(12'h041, 8'h22);
    exp_prog(12'h042, 8'h33); exp_prog(12'h043, 8'h44); push_w('0, 8'hFF);
    fire(0, 12'h040, 4);
    wait_done("R4 program done");
    end_checks("R4 program", 0, 0, 0, 0);
    chk(strm_q.size() == 0, "R4 stream drained", strm_q.size(), 0);
    stall_en = 0;

    // R6 R10 hardware failure on third byte
    set_status(1); rdy_seq[2] = 8'h82;
    strm_q = '{8'hA1, 8'hA2, 8'hA3, 8'hA4};
    exp_prog(12'h200, 8'hA1); exp_prog(12'h201, 8'hA2); exp_prog(12'h202, 8'hA3);
    fire(0, 12'h200, 4);
    wait_done("R6 fail done");
    end_checks("R6 hw fail", 1, 0, 8'h82, 12'h202);
    repeat (10) @(negedge clk);
    chk(err && err_status == 8'h82 && err_off == 12'h202, "R10 hold", err_status, 8'h82);
    strm_q.delete();

    // R7 erase timeout; R10 cleared by start
    set_status(50); erase_tmo = 16'd5;
    push_w('0, 8'hFF); push_w(12'h300, 8'h20); push_w(12'h300, 8'hD0);
    fire(1, 12'h300, 0);
    chk(!err, "R10 cleared at start", err, 0);
    wait_done("R7 erase tmo done");
    end_checks("R7 erase timeout", 1, 1, 8'h00, 12'h300);

    // R7 ready wins over expired limit
    set_status(0); erase_tmo = 16'd0;
    push_w('0, 8'hFF); push_w(12'h010, 8'h20); push_w(12'h010, 8'hD0); push_w('0, 8'hFF);
    fire(1, 12'h010, 0);
    wait_done("R7 ready wins done");
    end_checks("R7 ready wins", 0, 0, 0, 0);

    // R7 program uses write limit
    set_status(6); erase_tmo = 16'd1000; write_tmo = 16'd2;
    strm_q = '{8'h5A};
    exp_prog(12'h0F0, 8'h5A);
    fire(0, 12'h0F0, 1);
    wait_done("R7 prog tmo done");
    end_checks("R7 write limit", 1, 1, 8'h00, 12'h0F0);

    // R7 erase uses erase limit
    set_status(6); erase_tmo = 16'd1000; write_tmo = 16'd0;
    push_w('0, 8'hFF); push_w(12'h500, 8'h20); push_w(12'h500, 8'hD0); push_w('0, 8'hFF);
    fire(1, 12'h500, 0);
    wait_done("R7 erase limit done");
    end_checks("R7 erase limit", 0, 0, 0, 0);

    // R8 per-byte restart
    set_status(6); write_tmo = 16'd14; erase_tmo = 16'd0;
    strm_q = '{8'h01, 8'h02, 8'h03};
    exp_prog(12'h600, 8'h01); exp_prog(12'h601, 8'h02); exp_prog(12'h602, 8'h03);
    push_w('0, 8'hFF);
    fire(0, 12'h600, 3);
    wait_done("R8 done");
    end_checks("R8 restart", 0, 0, 0, 0);

    // R12 zero-length program
    set_status(0); strm_q = '{8'hEE};
    push_w('0, 8'hFF); push_w('0, 8'hFF);
    fire(0, 12'h700, 0);
    wait_done("R12 done");
    end_checks("R12 zero len", 0, 0, 0, 0);
    chk(strm_q.size() == 1, "R12 byte untouched", strm_q.size(), 1);
    strm_q.delete();

    // R11 start while busy ignored
    set_status(20); erase_tmo = 16'd1000;
    push_w('0, 8'hFF); push_w(12'h080, 8'h20); push_w(12'h080, 8'hD0); push_w('0, 8'hFF);
    fire(1, 12'h080, 0);
    repeat (6) @(negedge clk);
    fire(0, 12'h7FF, 2);
    wait_done("R11 done");
    end_checks("R11 ignored start", 0, 0, 0, 0);
    repeat (30) @(negedge clk);
    chk(!busy && !done, "R11 no second op", busy, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule